// File: doc/BRIEF.md
# Framed Serial Register Access Slave

This block is the command half of a serial slave. The slave is framed by an active-low chip select. It owns a 16-bit configuration register and two 9-bit reference trim registers. All three serial inputs (chip select, serial clock and data in) come from a slow external interface. The block synchronises them into a fast system clock and acts on the edges it detects. In each frame it captures a 16-bit control word, most significant bit first. It also counts the falling edges of the serial clock. When chip select returns high, the 4-bit opcode in the top of the word is acted on.

A write becomes permanent only when the frame was long enough. The minimum length depends on the interface mode held in two configuration bits. That mode is the one in force when the frame began. A short frame is an abort and leaves every register untouched. A register read is requested in one frame and delivered in the next one. During that delivery the block drives a readback bit stream, which the surrounding conversion-data logic places on the first serial data output.

Top module: `sreg_access`

## Requirements
- R1: After reset the configuration register is 0000 hex and both trim registers are 1FF hex. The commit strobe and the readback stream are both low.
- R2: Only the first 16 data bits of a frame form the control word, taken one per serial-clock falling edge, most significant first. Bits after the 16th do not change the decoded command or the data written.
- R3: In a committed frame, opcode bits [15:12] select the write. Opcode 1000 loads control-word bits [11:0] into configuration bits [11:0], and configuration bits [15:12] read as zero. Opcode 1001 loads bits [11:3] into trim A. Opcode 1010 loads bits [11:3] into trim B.
- R4: Opcodes 0000 and 1011, and every opcode with bit 14 set, change no register and request no readback.
- R5: A frame commits only if it has at least N serial-clock falling edges. N comes from configuration bits [11:10]: 00 gives 32, 01 gives 48, 10 gives 16 and 11 gives 32. A shorter frame changes no register.
- R6: N is taken from the configuration in force when chip select fell. A new mode written in the frame applies from the next frame onward.
- R7: After a frame that commits (a read or no-op frame counts, if long enough), the output frame_ok is high for exactly one system clock. It stays low after an aborted frame.
- R8: A read request in a committed frame of at least 48 edges makes the next frame a readback frame. Before its first falling edge, rb_sdo shows image bit 15. Each falling edge advances one bit, and after 16 edges rb_sdo is 0. Outside a readback frame, rb_sdo is 0.
- R9: The readback image is built per register. For the configuration register it is 0011 followed by configuration bits [11:0]. For trim A it is 0001, the nine trim bits, then 000. For trim B it is 0010, the nine trim bits, then 000.
- R10: A read request in a committed frame shorter than 48 edges, or in an aborted frame, schedules no readback. A readback is delivered in one frame only.
- R11: The edge count saturates at 63, so a frame of any greater length still commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| cfg_q | output | 16 | Configuration register |
| trim_a_q | output | 9 | Reference trim A |
| trim_b_q | output | 9 | Reference trim B |
| rb_word_q | output | 16 | Image scheduled for readback |
| rb_active_q | output | 1 | Current frame is a readback frame |
| rb_sdo_q | output | 1 | Readback bit for the first data output |
| frame_ok_q | output | 1 | One-cycle commit strobe at frame end |

## Verification
Random frames mix all sixteen opcodes with lengths from 10 to 70 edges and random data after the 16th bit. These frames separate the mode thresholds from each other, separate the 48-edge readback limit from the write limit, and test that tail bits are ignored. Directed frames use lengths exactly one below and exactly at each threshold. One directed frame switches mode inside a frame, to tell the old threshold from the new one. Read requests of 40 and 48 edges, each followed by a second frame, show that the readback is delivered only once and only after a long enough request. A frame of 100 edges exercises the saturating counter.

// File: rtl/sra_pkg.sv
package sra_pkg;

  typedef enum logic [2:0] {
    K_NOP, K_RD_CFG, K_RD_A, K_RD_B, K_WR_CFG, K_WR_A, K_WR_B
  } cmd_kind_e;

  // Opcode map; bit 14 set always means no operation.
  function automatic cmd_kind_e decode_op(input logic [3:0] op);
    cmd_kind_e k;
    k = K_NOP;
    if (!op[2]) begin
      case ({op[3], op[1:0]})
        3'b001:  k = K_RD_A;
        3'b010:  k = K_RD_B;
        3'b011:  k = K_RD_CFG;
        3'b100:  k = K_WR_CFG;
        3'b101:  k = K_WR_A;
        3'b110:  k = K_WR_B;
        default: k = K_NOP;
      endcase
    end
    return k;
  endfunction

  function automatic logic is_read(input cmd_kind_e k);
    return (k == K_RD_CFG) || (k == K_RD_A) || (k == K_RD_B);
  endfunction

  // Minimum falling edges for a frame to commit, per interface mode.
  function automatic int min_edges(input logic [1:0] mode);
    case (mode)
      2'b01:   return 48;
      2'b10:   return 16;
      default: return 32;
    endcase
  endfunction

endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/sra_frame.sv
module sra_frame import sra_pkg::*; #(
  parameter int CNT_W  = 6,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic [1:0]        mode,
  output logic              cs_fall,
  output logic              cs_rise,
  output logic              frame_act,
  output logic [CNT_W-1:0]  edge_cnt,
  output logic [WORD_W-1:0] cmd_word,
  output logic [CNT_W-1:0]  need_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CMD_BITS = CNT_W'(WORD_W);

  logic prev_cs, prev_sclk, sclk_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_cs   <= 1'b1;
      prev_sclk <= 1'b0;
    end else begin
      prev_cs   <= cs_s;
      prev_sclk <= sclk_s;
    end
  end

  assign cs_fall   = prev_cs & ~cs_s;
  assign cs_rise   = ~prev_cs & cs_s;
  assign sclk_fall = prev_sclk & ~sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_act <= 1'b0;
      edge_cnt  <= '0;
      cmd_word  <= '0;
      need_cnt  <= CNT_W'(min_edges(2'b00));
    end else if (cs_fall) begin
      frame_act <= 1'b1;
      edge_cnt  <= '0;
      cmd_word  <= '0;
      need_cnt  <= CNT_W'(min_edges(mode));
    end else if (cs_rise) begin
      frame_act <= 1'b0;
    end else if (frame_act && sclk_fall) begin
      if (edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
      if (edge_cnt < CMD_BITS) cmd_word <= {cmd_word[WORD_W-2:0], sdi_s};
    end
  end
endmodule

// File: rtl/sra_regs.sv
module sra_regs import sra_pkg::*; #(
  parameter int              CNT_W    = 6,
  parameter int              WORD_W   = 16,
  parameter int              TRIM_W   = 9,
  parameter int              RB_EDGES = 48,
  parameter logic [TRIM_W-1:0] TRIM_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              frame_act,
  input  logic [CNT_W-1:0]  edge_cnt,
  input  logic [CNT_W-1:0]  need_cnt,
  input  logic [WORD_W-1:0] cmd_word,
  output logic [WORD_W-1:0] cfg_q,
  output logic [TRIM_W-1:0] trim_a_q,
  output logic [TRIM_W-1:0] trim_b_q,
  output logic [WORD_W-1:0] rb_word_q,
  output logic              rb_active_q,
  output logic              rb_sdo_q,
  output logic              frame_ok_q
);
  localparam int OP_W     = 4;
  localparam int DATA_W   = WORD_W - OP_W;
  localparam int TRIM_LSB = DATA_W - TRIM_W;
  localparam int IDX_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] RB_MIN   = CNT_W'(RB_EDGES);
  localparam logic [CNT_W-1:0] RB_BITS  = CNT_W'(WORD_W);
  localparam logic [IDX_W-1:0] TOP_IDX  = IDX_W'(WORD_W - 1);

  logic [OP_W-1:0]   op;
  cmd_kind_e         kind;
  logic              len_ok, rb_len, rd_req, rb_pend_q;
  logic [WORD_W-1:0] image;
  logic [TRIM_W-1:0] wr_trim;

  assign op      = cmd_word[WORD_W-1 -: OP_W];
  assign kind    = decode_op(op);
  assign len_ok  = edge_cnt >= need_cnt;
  assign rb_len  = edge_cnt >= RB_MIN;
  assign rd_req  = len_ok && rb_len && is_read(kind);
  assign wr_trim = cmd_word[DATA_W-1 -: TRIM_W];

  always_comb begin
    case (kind)
      K_RD_CFG: image = {op, cfg_q[DATA_W-1:0]};
      K_RD_A:   image = {op, trim_a_q, {TRIM_LSB{1'b0}}};
      K_RD_B:   image = {op, trim_b_q, {TRIM_LSB{1'b0}}};
      default:  image = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q       <= '0;
      trim_a_q    <= TRIM_RST;
      trim_b_q    <= TRIM_RST;
      rb_word_q   <= '0;
      rb_pend_q   <= 1'b0;
      rb_active_q <= 1'b0;
      frame_ok_q  <= 1'b0;
    end else begin
      frame_ok_q <= 1'b0;
      if (cs_fall) begin
        rb_active_q <= rb_pend_q;
        rb_pend_q   <= 1'b0;
      end
      if (cs_rise && frame_act) begin
        rb_active_q <= 1'b0;
        frame_ok_q  <= len_ok;
        rb_pend_q   <= rd_req;
        if (rd_req) rb_word_q <= image;
        if (len_ok) begin
          case (kind)
            K_WR_CFG: cfg_q    <= {{OP_W{1'b0}}, cmd_word[DATA_W-1:0]};
            K_WR_A:   trim_a_q <= wr_trim;
            K_WR_B:   trim_b_q <= wr_trim;
            default:  ;
          endcase
        end
      end
    end
  end

  // Readback bit: image MSB first, advancing per counted falling edge.
  always_ff @(posedge clk) begin
    if (rst) rb_sdo_q <= 1'b0;
    else if (rb_active_q && edge_cnt < RB_BITS)
      rb_sdo_q <= rb_word_q[TOP_IDX - edge_cnt[IDX_W-1:0]];
    else rb_sdo_q <= 1'b0;
  end
endmodule

// File: rtl/sreg_access.sv
module sreg_access #(
  parameter int                CNT_W       = 6,
  parameter int                WORD_W      = 16,
  parameter int                TRIM_W      = 9,
  parameter int                SYNC_STAGES = 2,
  parameter int                RB_EDGES    = 48,
  parameter logic [TRIM_W-1:0] TRIM_RST    = 9'h1FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [WORD_W-1:0] cfg_q,
  output logic [TRIM_W-1:0] trim_a_q,
  output logic [TRIM_W-1:0] trim_b_q,
  output logic [WORD_W-1:0] rb_word_q,
  output logic              rb_active_q,
  output logic              rb_sdo_q,
  output logic              frame_ok_q
);
  localparam int N_IN = 3;
  localparam int MODE_HI = WORD_W - 5;

  logic [N_IN-1:0]   pins_s;
  logic              cs_fall, cs_rise, frame_act;
  logic [CNT_W-1:0]  edge_cnt, need_cnt;
  logic [WORD_W-1:0] cmd_word;

  sra_sync #(.W(N_IN), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) i_sync (
    .clk(clk), .rst(rst), .d({cs_n, sclk, sdi}), .q(pins_s)
  );

  sra_frame #(.CNT_W(CNT_W), .WORD_W(WORD_W)) i_frame (
    .clk(clk), .rst(rst),
    .cs_s(pins_s[2]), .sclk_s(pins_s[1]), .sdi_s(pins_s[0]),
    .mode(cfg_q[MODE_HI -: 2]),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .frame_act(frame_act),
    .edge_cnt(edge_cnt), .cmd_word(cmd_word), .need_cnt(need_cnt)
  );

  sra_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W), .TRIM_W(TRIM_W),
             .RB_EDGES(RB_EDGES), .TRIM_RST(TRIM_RST)) i_regs (
    .clk(clk), .rst(rst),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .frame_act(frame_act),
    .edge_cnt(edge_cnt), .need_cnt(need_cnt), .cmd_word(cmd_word),
    .cfg_q(cfg_q), .trim_a_q(trim_a_q), .trim_b_q(trim_b_q),
    .rb_word_q(rb_word_q), .rb_active_q(rb_active_q),
    .rb_sdo_q(rb_sdo_q), .frame_ok_q(frame_ok_q)
  );
endmodule

// File: rtl/sra_checker.sv
module sra_checker #(
  parameter int CNT_W  = 6,
  parameter int WORD_W = 16,
  parameter int TRIM_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_act,
  input logic [CNT_W-1:0]  edge_cnt,
  input logic [WORD_W-1:0] cfg_q,
  input logic [TRIM_W-1:0] trim_a_q,
  input logic [TRIM_W-1:0] trim_b_q,
  input logic              rb_active_q,
  input logic              rb_sdo_q,
  input logic              frame_ok_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_ok_q |=> !frame_ok_q);  // R7

  AST_CFG_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg_q) |-> frame_ok_q);  // R5

  AST_TRIM_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (!$stable(trim_a_q) || !$stable(trim_b_q)) |-> frame_ok_q);  // R3

  AST_CNT_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (rst)
    (frame_act && $past(frame_act) && $past(edge_cnt) == CNT_MAX) |-> edge_cnt == CNT_MAX);  // R11

  AST_CNT_NO_DECREASE: assert property (@(posedge clk) disable iff (rst)
    (frame_act && $past(frame_act)) |-> edge_cnt >= $past(edge_cnt));  // R2

  AST_RB_INSIDE_FRAME: assert property (@(posedge clk) disable iff (rst)
    rb_active_q |-> frame_act);  // R8

  AST_RB_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
    (!rb_active_q && !$past(rb_active_q)) |-> !rb_sdo_q);  // R8
endmodule

bind sreg_access sra_checker #(.CNT_W(CNT_W), .WORD_W(WORD_W), .TRIM_W(TRIM_W)) i_chk (
  .clk(clk), .rst(rst), .frame_act(frame_act), .edge_cnt(edge_cnt),
  .cfg_q(cfg_q), .trim_a_q(trim_a_q), .trim_b_q(trim_b_q),
  .rb_active_q(rb_active_q), .rb_sdo_q(rb_sdo_q), .frame_ok_q(frame_ok_q)
);

// File: tb/test_sreg_access.sv
`timescale 1ns/1ps
module test_sreg_access;
  localparam int HOLD = 5;

  logic clk = 1'b0;
  logic rst, cs_n, sclk, sdi;
  logic [15:0] cfg_q, rb_word_q;
  logic [8:0]  trim_a_q, trim_b_q;
  logic        rb_active_q, rb_sdo_q, frame_ok_q;

  int checks = 0, errors = 0, ok_pulses = 0;

  logic [15:0] mcfg, mimg;
  logic [8:0]  mta, mtb;
  bit          mpend;

  always #4 clk = ~clk;

  sreg_access i_sreg_access (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .cfg_q(cfg_q), .trim_a_q(trim_a_q), .trim_b_q(trim_b_q),
    .rb_word_q(rb_word_q), .rb_active_q(rb_active_q),
    .rb_sdo_q(rb_sdo_q), .frame_ok_q(frame_ok_q)
  );

  always @(posedge clk) if (!rst && frame_ok_q) ok_pulses++;

  function automatic int need_of(input logic [15:0] c);
    case (c[11:10])
      2'b01:   return 48;
      2'b10:   return 16;
      default: return 32;
    endcase
  endfunction

  task automatic check(input bit cond, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_regs(input string tag);
    check(cfg_q == mcfg, tag, "cfg", cfg_q, mcfg);
    check(trim_a_q == mta, tag, "trim A", trim_a_q, mta);
    check(trim_b_q == mtb, tag, "trim B", trim_b_q, mtb);
  endtask

  task automatic run_frame(input logic [15:0] w, input int edges,
                           input bit tail_rand, input string tag);
    int ne, need, bad, p0;
    bit valid, exp_b;
    need = need_of(mcfg);
    ne   = (edges > 63) ? 63 : edges;
    p0   = ok_pulses;
    bad  = 0;
    cs_n = 1'b0;
    repeat (HOLD) @(negedge clk);
    for (int k = 0; k < edges; k++) begin
      exp_b = mpend && (k < 16) ? mimg[15-k] : 1'b0;
      if (rb_sdo_q !== exp_b) bad++;
      sdi  = (k < 16) ? w[15-k] : (tail_rand ? 1'($urandom % 2) : 1'b0);
      sclk = 1'b1;
      repeat (HOLD) @(negedge clk);
      sclk = 1'b0;
      repeat (HOLD) @(negedge clk);
    end
    cs_n = 1'b1;
    sdi  = 1'b0;
    repeat (HOLD) @(negedge clk);
    check(bad == 0, "R8", "readback stream mismatches", bad, 0);
    // Reference model of the commit at frame end.
    valid = ne >= need;
    mpend = 1'b0;
    if (valid && !w[14]) begin
      case ({w[15], w[13:12]})
        3'b100: mcfg = {4'h0, w[11:0]};
        3'b101: mta  = w[11:3];
        3'b110: mtb  = w[11:3];
        3'b001: begin mpend = ne >= 48; mimg = {4'h1, mta, 3'b000}; end
        3'b010: begin mpend = ne >= 48; mimg = {4'h2, mtb, 3'b000}; end
        3'b011: begin mpend = ne >= 48; mimg = {4'h3, mcfg[11:0]}; end
        default: ;
      endcase
    end
    check(ok_pulses - p0 == int'(valid), "R7", "commit strobes", ok_pulses - p0, int'(valid));
    check_regs(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    mcfg = 16'h0000; mta = 9'h1FF; mtb = 9'h1FF; mpend = 1'b0; mimg = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check_regs("R1");
    check(frame_ok_q == 1'b0, "R1", "strobe", frame_ok_q, 0);
    check(rb_sdo_q == 1'b0, "R1", "readback bit", rb_sdo_q, 0);

    run_frame({4'h9, 9'h0A5, 3'b000}, 32, 1'b0, "R3");   // trim A write
    run_frame({4'hA, 9'h13C, 3'b000}, 31, 1'b0, "R5");   // one short: abort
    run_frame({4'hA, 9'h13C, 3'b000}, 32, 1'b1, "R2");   // tail bits random
    run_frame({4'hB, 12'hFFF}, 40, 1'b0, "R4");
    run_frame({4'h4, 12'hABC}, 40, 1'b0, "R4");
    run_frame({4'hC, 12'h123}, 40, 1'b0, "R4");
    run_frame({4'h8, 12'h800}, 16, 1'b0, "R6");          // old mode needs 32
    run_frame({4'h8, 12'h800}, 32, 1'b0, "R3");          // mode 10 in force
    run_frame({4'h9, 9'h111, 3'b000}, 16, 1'b0, "R5");
    run_frame({4'h8, 12'h400}, 16, 1'b0, "R6");          // switch to mode 01
    run_frame({4'h9, 9'h0F0, 3'b000}, 47, 1'b0, "R5");
    run_frame({4'h9, 9'h0F0, 3'b000}, 48, 1'b0, "R5");
    run_frame({4'h1, 12'h000}, 48, 1'b0, "R9");          // request trim A
    run_frame({4'h0, 12'h000}, 48, 1'b0, "R8");          // delivers it
    run_frame({4'h0, 12'h000}, 48, 1'b0, "R10");         // only once
    run_frame({4'h8, 12'hC00}, 48, 1'b0, "R5");          // mode 11
    run_frame({4'h3, 12'h000}, 40, 1'b0, "R10");         // valid, too short
    run_frame({4'h0, 12'h000}, 40, 1'b0, "R10");
    run_frame({4'h3, 12'h000}, 50, 1'b0, "R9");          // request cfg
    run_frame({4'h2, 12'h000}, 48, 1'b1, "R9");          // delivers, requests B
    run_frame({4'h0, 12'h000}, 20, 1'b0, "R8");          // B delivered, short frame
    run_frame({4'h9, 9'h1AB, 3'b000}, 100, 1'b1, "R11");

    for (int i = 0; i < 50; i++) begin
      logic [3:0]  op;
      logic [11:0] dat;
      op  = 4'($urandom % 16);
      dat = 12'($urandom);
      if (op == 4'h8) dat[11:10] = 2'($urandom % 4);
      run_frame({op, dat}, int'($urandom_range(10, 70)), 1'b1, "R5");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule